// File: doc/BRIEF.md
# Card Controller Interrupt Aggregator with DMA Steering

This block gathers the thirteen event sources of a memory-card host controller into one pending register. It drives a single interrupt line to the CPU from that register. Each source has a set input and a clear input. A mask register sets which sources may raise the interrupt. Software reaches both registers through a small word-addressed register bus.

When the controller runs in DMA mode, the two FIFO service requests are held off the CPU interrupt. The block presents them instead as level request lines to a DMA engine. The FIFO service requests are the receive request and the transmit request. All three outputs are registered. The event logic and the DMA engine sit outside this block.

Top module: `irq_dma_router`

## Requirements
- R1: During and after synchronous reset, the pending and mask registers are zero and `irq`, `dma_rx_req` and `dma_tx_req` are low.
- R2: Pending bit positions are: 0 data done, 1 program done, 2 end of command, 3 stop command, 4 clock off, 5 receive FIFO request, 6 transmit FIFO request, 7 tint, 8 data error, 9 response error, 10 read stalled, 11 SDIO interrupt, 12 SDIO acknowledge. A high `src_set[i]` in a cycle sets pending bit i at the next edge.
- R3: A high `src_clr[i]` clears pending bit i at the next edge. When set and clear hit the same bit in one cycle, the bit ends up set.
- R4: A bus write to address 0 loads the mask from `bus_wdata[12:0]`. The upper data bits are dropped. A mask bit of 1 disables that source.
- R5: A bus write to address 1 replaces the pending register with `bus_wdata[12:0]`. Clear and set inputs of the same cycle are applied on top of the written value, set last.
- R6: `irq` is high when some pending bit is 1 and its effective mask bit is 0. It reflects register state one edge after that state changes.
- R7: While `dma_mode` is high, pending bits 5 and 6 are part of the effective mask. The outputs follow a change of `dma_mode` at the next edge.
- R8: While `dma_mode` is high, `dma_rx_req` follows pending bit 5 and `dma_tx_req` follows pending bit 6, one edge later.
- R9: While `dma_mode` is low, both DMA request lines are low.
- R10: A `clk_stop` pulse sets pending bit 4. A `clk_start` pulse clears it. If both are high in one cycle, the bit ends up set.
- R11: `bus_rdata` returns the mask for address 0, the pending register for address 1 and zero for any other address, zero-extended, one edge after `bus_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW (2) | Register word address |
| bus_wdata | input | DW (32) | Register write data |
| bus_rdata | output | DW (32) | Registered read data |
| src_set | input | 13 | Per-source set events |
| src_clr | input | 13 | Per-source clear events |
| clk_stop | input | 1 | Card clock stop command |
| clk_start | input | 1 | Card clock start command |
| dma_mode | input | 1 | DMA mode enable from the command control register |
| irq | output | 1 | CPU interrupt line |
| dma_rx_req | output | 1 | Receive FIFO DMA request |
| dma_tx_req | output | 1 | Transmit FIFO DMA request |

## Verification
The first sweep walks a single pending bit across all thirteen positions. For each position it tries two masks: one masking only that bit, and one masking every other bit. It does this with DMA mode off and on. This separates a wrong bit position or an inverted mask from the FIFO bits being forced masked and steered to the DMA lines. A second pass runs pseudo-random pending, mask and mode combinations. That pass catches any stray term in the OR reduction. Directed cases cover the set/clear collision over many bits at once, a register write racing a set event, and clock stop/start alone and together. They also cover address decoding and the upper write bits that must be dropped.

// File: rtl/irq_dma_router_pkg.sv
package irq_dma_router_pkg;
  localparam int NSRC = 13;

  localparam int SRC_DATA_DONE = 0;
  localparam int SRC_PROG_DONE = 1;
  localparam int SRC_CMD_END   = 2;
  localparam int SRC_STOP_CMD  = 3;
  localparam int SRC_CLK_OFF   = 4;
  localparam int SRC_RX_REQ    = 5;
  localparam int SRC_TX_REQ    = 6;
  localparam int SRC_TINT      = 7;
  localparam int SRC_DAT_ERR   = 8;
  localparam int SRC_RSP_ERR   = 9;
  localparam int SRC_RD_STALL  = 10;
  localparam int SRC_SDIO_IRQ  = 11;
  localparam int SRC_SDIO_ACK  = 12;

  localparam int REG_MASK = 0;
  localparam int REG_PEND = 1;
endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [N-1:0] wr_val,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic base;
    always_comb begin
      base      = wr_en ? wr_val[i] : pend_q[i];
      pend_d[i] = (base & ~clr_i[i]) | set_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [N-1:0] wr_val,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (wr_en) mask_q <= wr_val;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int N      = 13,
  parameter int RX_BIT = 5,
  parameter int TX_BIT = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] mask,
  input  logic         dma_mode,
  output logic         irq_o,
  output logic         rx_o,
  output logic         tx_o
);
  localparam logic [N-1:0] FIFO_BITS = (N'(1) << RX_BIT) | (N'(1) << TX_BIT);

  logic [N-1:0] eff_mask;
  logic [N-1:0] live;

  always_comb begin
    eff_mask = mask | (dma_mode ? FIFO_BITS : '0);
    live     = pend & ~eff_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      rx_o  <= 1'b0;
      tx_o  <= 1'b0;
    end else begin
      irq_o <= |live;
      rx_o  <= dma_mode & pend[RX_BIT];
      tx_o  <= dma_mode & pend[TX_BIT];
    end
  end
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
  import irq_dma_router_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  input  logic            clk_stop,
  input  logic            clk_start,
  input  logic            dma_mode,
  output logic            irq,
  output logic            dma_rx_req,
  output logic            dma_tx_req
);
  localparam int PAD = DW - NSRC;
  localparam logic [NSRC-1:0] CLK_OFF_BIT = NSRC'(1) << SRC_CLK_OFF;

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] set_all;
  logic [NSRC-1:0] clr_all;
  logic            wr_mask;
  logic            wr_pend;
  logic [DW-1:0]   rd_next;
  logic            unused_hi;

  assign unused_hi = ^bus_wdata[DW-1:NSRC];

  always_comb begin
    wr_mask = bus_wr && (bus_addr == AW'(REG_MASK));
    wr_pend = bus_wr && (bus_addr == AW'(REG_PEND));
    set_all = src_set | (clk_stop  ? CLK_OFF_BIT : '0);
    clr_all = src_clr | (clk_start ? CLK_OFF_BIT : '0);
  end

  irq_pending_reg #(.N(NSRC)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_pend),
    .wr_val (bus_wdata[NSRC-1:0]),
    .set_i  (set_all),
    .clr_i  (clr_all),
    .pend_o (pend_q)
  );

  irq_mask_reg #(.N(NSRC)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_mask),
    .wr_val (bus_wdata[NSRC-1:0]),
    .mask_o (mask_q)
  );

  irq_steer #(.N(NSRC), .RX_BIT(SRC_RX_REQ), .TX_BIT(SRC_TX_REQ)) u_steer (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend_q),
    .mask     (mask_q),
    .dma_mode (dma_mode),
    .irq_o    (irq),
    .rx_o     (dma_rx_req),
    .tx_o     (dma_tx_req)
  );

  always_comb begin
    if (bus_addr == AW'(REG_MASK))      rd_next = {{PAD{1'b0}}, mask_q};
    else if (bus_addr == AW'(REG_PEND)) rd_next = {{PAD{1'b0}}, pend_q};
    else                                rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk
  import irq_dma_router_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NSRC-1:0] src_set,
  input logic            clk_stop,
  input logic            clk_start,
  input logic            dma_mode,
  input logic            irq,
  input logic            dma_rx_req,
  input logic            dma_tx_req,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q
);
  localparam logic [NSRC-1:0] FIFO_PAIR = 13'h0060;

  logic [NSRC-1:0] open_bits;
  assign open_bits = pend_q & ~(mask_q | (dma_mode ? FIFO_PAIR : '0));

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(src_set) & ~pend_q) == '0)); // R3

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_wr && bus_addr == AW'(REG_MASK)) |-> mask_q == $past(bus_wdata[NSRC-1:0])); // R4

  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == $past(|open_bits)); // R6

  AST_DMA_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && dma_mode) |-> (dma_rx_req == $past(pend_q[SRC_RX_REQ]) &&
                                 dma_tx_req == $past(pend_q[SRC_TX_REQ]))); // R8

  AST_DMA_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!dma_mode) |-> (!dma_rx_req && !dma_tx_req)); // R9

  AST_CLKOFF_SET: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && clk_stop) |-> pend_q[SRC_CLK_OFF]); // R10

  AST_CLKOFF_CLR: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && clk_start && !clk_stop && !src_set[SRC_CLK_OFF]) |-> !pend_q[SRC_CLK_OFF]); // R10

  AST_RD_OTHER: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_addr != AW'(REG_MASK) && bus_addr != AW'(REG_PEND)) |-> bus_rdata == '0); // R11
endmodule

bind irq_dma_router irq_dma_router_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .src_set    (src_set),
  .clk_stop   (clk_stop),
  .clk_start  (clk_start),
  .dma_mode   (dma_mode),
  .irq        (irq),
  .dma_rx_req (dma_rx_req),
  .dma_tx_req (dma_tx_req),
  .pend_q     (pend_q),
  .mask_q     (mask_q)
);

// File: tb/irq_dma_router_test.sv
`timescale 1ns/1ps
module irq_dma_router_test;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam int N  = 13;
  localparam logic [N-1:0] ALL = 13'h1FFF;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0]  src_set;
  logic [N-1:0]  src_clr;
  logic          clk_stop;
  logic          clk_start;
  logic          dma_mode;
  logic          irq;
  logic          dma_rx_req;
  logic          dma_tx_req;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_dma_router #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_set(src_set),
    .src_clr(src_clr), .clk_stop(clk_stop), .clk_start(clk_start),
    .dma_mode(dma_mode), .irq(irq), .dma_rx_req(dma_rx_req),
    .dma_tx_req(dma_tx_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int addr, input logic [31:0] data);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic reg_read(input int addr, output logic [31:0] data);
    bus_addr = AW'(addr);
    @(negedge clk);
    data = bus_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] s, input logic [N-1:0] c, input logic stp, input logic sta);
    src_set = s; src_clr = c; clk_stop = stp; clk_start = sta;
    @(negedge clk);
    src_set = '0; src_clr = '0; clk_stop = 1'b0; clk_start = 1'b0;
  endtask

  function automatic logic exp_irq(input logic [N-1:0] p, input logic [N-1:0] m, input logic d);
    logic [N-1:0] em;
    em = m | (d ? 13'h0060 : 13'h0000);
    return |(p & ~em);
  endfunction

  task automatic check_outs(input string req, input logic [N-1:0] p, input logic [N-1:0] m, input logic d);
    check(req, {31'd0, irq}, {31'd0, exp_irq(p, m, d)});
    check(req, {31'd0, dma_rx_req}, {31'd0, d & p[5]});
    check(req, {31'd0, dma_tx_req}, {31'd0, d & p[6]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] lfsr;
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    src_set = '0; src_clr = '0; clk_stop = 1'b0; clk_start = 1'b0; dma_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 dma", {30'd0, dma_rx_req, dma_tx_req}, 32'd0);
    rst = 1'b0;
    reg_read(1, rd); check("R1 pend", rd, 32'd0);
    reg_read(0, rd); check("R1 mask", rd, 32'd0);

    // R2: each set input lands on its own bit
    for (int i = 0; i < N; i++) begin
      reg_write(1, 32'd0);
      pulse(N'(1) << i, '0, 1'b0, 1'b0);
      reg_read(1, rd);
      check("R2 set bit", rd, 32'd1 << i);
    end

    // R3: clears, and set beats clear on collision
    reg_write(1, 32'h1FFF);
    pulse(13'h0101, 13'h1555, 1'b0, 1'b0);
    reg_read(1, rd);
    check("R3 set over clear", rd, 32'h0BAB);

    // R4: mask write drops upper bits
    reg_write(0, 32'hFFFF_FFFF);
    reg_read(0, rd);
    check("R4 mask width", rd, 32'h1FFF);

    // R5: pending write racing set and clear
    reg_write(1, 32'h1FFF);
    bus_wr = 1'b1; bus_addr = AW'(1); bus_wdata = 32'hFFFF_0030;
    src_set = 13'h0008; src_clr = 13'h0010;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; src_set = '0; src_clr = '0;
    reg_read(1, rd);
    check("R5 write then set", rd, 32'h0028);

    // R11: unmapped addresses read zero
    reg_read(2, rd); check("R11 addr2", rd, 32'd0);
    reg_read(3, rd); check("R11 addr3", rd, 32'd0);

    // R10: clock stop/start on bit 4
    reg_write(1, 32'd0);
    pulse('0, '0, 1'b1, 1'b0);
    reg_read(1, rd); check("R10 stop", rd, 32'h10);
    pulse('0, '0, 1'b0, 1'b1);
    reg_read(1, rd); check("R10 start", rd, 32'h0);
    pulse('0, '0, 1'b1, 1'b1);
    reg_read(1, rd); check("R10 both", rd, 32'h10);

    // R6 R7 R8 R9: walking bit sweep over mask shape and mode
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < N; i++) begin
        for (int k = 0; k < 2; k++) begin
          logic [N-1:0] p;
          logic [N-1:0] m;
          p = N'(1) << i;
          m = (k == 0) ? p : (ALL & ~p);
          dma_mode = d[0];
          reg_write(1, {19'd0, p});
          reg_write(0, {19'd0, m});
          @(negedge clk);
          check_outs(d[0] ? "R7 R8 sweep" : "R6 R9 sweep", p, m, d[0]);
        end
      end
    end

    // R7: mode change alone takes effect after one edge
    reg_write(0, 32'd0);
    reg_write(1, 32'h0020);
    dma_mode = 1'b0;
    @(negedge clk);
    check_outs("R7 mode off", 13'h0020, 13'h0, 1'b0);
    dma_mode = 1'b1;
    @(negedge clk);
    check_outs("R7 mode on", 13'h0020, 13'h0, 1'b1);

    // R6 R8 R9: pseudo-random patterns
    lfsr = 32'hACE1_2468;
    for (int t = 0; t < 150; t++) begin
      logic [N-1:0] p;
      logic [N-1:0] m;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      p = lfsr[12:0];
      m = lfsr[25:13] & {N{lfsr[26]}};
      dma_mode = lfsr[27];
      reg_write(1, {19'd0, p});
      reg_write(0, {19'd0, m});
      @(negedge clk);
      check_outs("R6 R8 R9 random", p, m, lfsr[27]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule